// File: doc/BRIEF.md
# PHY Reset Pulse Sequencer

This block drives the hardware reset line of an external Ethernet PHY through a fixed three-step sequence. A one-cycle start strobe launches it. The line is first held released for a settling interval. It is then driven active for the pulse width. Finally it is released again and the block waits out a recovery interval. All three intervals are given in microseconds, and each one can be set to any value, including zero.

A prescaler turns the system clock into a microsecond time base. The number of clock cycles per microsecond comes from two frequency parameters. The block reports a busy flag while a sequence is in progress. At the very end it gives a single-cycle done pulse, which tells the management-bus logic that the PHY may be addressed again. Power management logic issues the strobe again when the system resumes from a low-power state.

Top module: `phyrst_seq`

## Requirements
- R1: After synchronous reset the line is at its released level, and busy and done are both 0.
- R2: A sequence first holds the line released, then drives it active, then releases it again, in that order. The active level is held for exactly the pulse interval.
- R3: Each interval of D microseconds lasts exactly D*CYC_PER_US clock cycles, where CYC_PER_US = CLK_HZ/TICK_HZ. The microsecond prescaler restarts at the accepted strobe.
- R4: An interval of zero is skipped and costs no cycles. When all three intervals are zero, done pulses in the cycle right after the strobe, busy never rises and the line never moves.
- R5: Done is high for exactly one cycle. That cycle is the one right after the recovery interval ends, and busy is already 0 during it. Done never comes earlier.
- R6: The three interval inputs are captured when the strobe is accepted. Changing them during a sequence has no effect on that sequence.
- R7: A start strobe that arrives while busy is high is ignored.
- R8: Line polarity is set by RST_ACTIVE_LOW. With the default of 1, the line is driven to 0 while active and rests at 1.
- R9: If the strobe is accepted at clock edge E0 and the intervals total T cycles, busy is high for the T cycles after E0 and low after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that launches a sequence |
| pre_us_i | input | DLY_W | Settling interval before the pulse, in microseconds |
| pulse_us_i | input | DLY_W | Active pulse width, in microseconds |
| post_us_i | input | DLY_W | Recovery interval after the pulse, in microseconds |
| phy_rst_o | output | 1 | Reset line to the PHY |
| busy_o | output | 1 | High while a sequence is running |
| done_o | output | 1 | One-cycle pulse when the PHY may be accessed again |

## Verification
All timing is counted from the clock edge at which the strobe is accepted. Cycle k is the k-th cycle after that edge. With intervals of a, b and c microseconds and N cycles per microsecond, the line is expected active in cycles a*N+1 through (a+b)*N. Busy is expected high in cycles 1 through (a+b+c)*N, and done is expected high only in the cycle after that. The bench samples every output on the falling edge of each of those cycles and compares it with the expected value for that cycle. Strobes and interval changes injected during a run must leave the expected waveform unchanged.

// File: rtl/phyrst_pkg.sv
// Shared types for the PHY reset sequencer: the phase encoding and the
// rule that picks the next phase whose interval is non-zero.
package phyrst_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRE   = 2'd1,
        PH_PULSE = 2'd2,
        PH_POST  = 2'd3
    } phase_e;

    // live[0]: settle interval non-zero, live[1]: pulse, live[2]: recovery
    function automatic phase_e phase_after(phase_e cur, logic [2:0] live);
        phase_e nxt;
        nxt = PH_IDLE;
        case (cur)
            PH_IDLE: begin
                if (live[0])      nxt = PH_PRE;
                else if (live[1]) nxt = PH_PULSE;
                else if (live[2]) nxt = PH_POST;
            end
            PH_PRE: begin
                if (live[1])      nxt = PH_PULSE;
                else if (live[2]) nxt = PH_POST;
            end
            PH_PULSE: begin
                if (live[2])      nxt = PH_POST;
            end
            default: nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/phyrst_us_tick.sv
// Microsecond prescaler. Counts enabled cycles and raises tick on the last
// cycle of every DIV-cycle period. Assumes DIV >= 1. A clear forces the
// count back to zero, so a new period starts on the following cycle.
module phyrst_us_tick #(
    parameter int unsigned DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    // Advance the cycle count and wrap at the end of each microsecond
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else if (en)     cnt_q <= cnt_q + 1'b1;
    end

    p_prescale_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/phyrst_phase_timer.sv
// Counts microsecond ticks within one phase. Expire fires on the tick that
// completes `limit` microseconds. Assumes the caller never runs a phase
// with a zero limit and clears the timer at each phase boundary.
module phyrst_phase_timer #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [DW-1:0] limit,
    output logic          expire
);
    logic [DW-1:0] us_q;

    assign expire = tick && (us_q == limit - DW'(1));

    // Count whole microseconds elapsed in the current phase
    always_ff @(posedge clk) begin
        if (!rst_n)     us_q <= '0;
        else if (clr)   us_q <= '0;
        else if (tick)  us_q <= us_q + 1'b1;
    end

    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && limit != '0) |-> (us_q < limit));

endmodule

// File: rtl/phyrst_seq.sv
// PHY reset sequencer top. On an accepted strobe it captures the three
// intervals and walks settle -> pulse -> recovery, skipping zero intervals.
// It then pulses done for one cycle. Assumes CLK_HZ is a multiple of TICK_HZ.
module phyrst_seq
    import phyrst_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 250_000_000,
    parameter int unsigned TICK_HZ        = 1_000_000,
    parameter int unsigned DLY_W          = 32,
    parameter bit          RST_ACTIVE_LOW = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DLY_W-1:0] pre_us_i,
    input  logic [DLY_W-1:0] pulse_us_i,
    input  logic [DLY_W-1:0] post_us_i,
    output logic             phy_rst_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int unsigned CYC_PER_US = CLK_HZ / TICK_HZ;
    localparam logic        ACT_LVL    = RST_ACTIVE_LOW ? 1'b0 : 1'b1;

    phase_e           state_q, state_d;
    logic [DLY_W-1:0] pre_q, pulse_q, post_q, lim;
    logic [2:0]       live_in, live_q;
    logic             accept, tick, phase_end, done_d, line_q;

    assign busy_o    = (state_q != PH_IDLE);
    assign phy_rst_o = line_q;
    assign accept    = start_i && (state_q == PH_IDLE);
    assign live_in   = {post_us_i != '0, pulse_us_i != '0, pre_us_i != '0};
    assign live_q    = {post_q != '0, pulse_q != '0, pre_q != '0};

    phyrst_us_tick #(.DIV(CYC_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (busy_o),
        .tick  (tick)
    );

    phyrst_phase_timer #(.DW(DLY_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept || phase_end),
        .tick   (tick),
        .limit  (lim),
        .expire (phase_end)
    );

    // Select the captured interval that belongs to the current phase
    always_comb begin
        case (state_q)
            PH_PRE:   lim = pre_q;
            PH_PULSE: lim = pulse_q;
            PH_POST:  lim = post_q;
            default:  lim = '0;
        endcase
    end

    // Decide the next phase and whether the sequence finishes now
    always_comb begin
        state_d = state_q;
        if (accept)         state_d = phase_after(PH_IDLE, live_in);
        else if (phase_end) state_d = phase_after(state_q, live_q);
        done_d = (accept || phase_end) && (state_d == PH_IDLE);
    end

    // Register phase, done pulse and the line level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            done_q  <= 1'b0;
            line_q  <= ~ACT_LVL;
        end else begin
            state_q <= state_d;
            done_q  <= done_d;
            line_q  <= (state_d == PH_PULSE) ? ACT_LVL : ~ACT_LVL;
        end
    end

    logic done_q;
    assign done_o = done_q;

    // Capture the three intervals only when a strobe is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            pulse_q <= '0;
            post_q  <= '0;
        end else if (accept) begin
            pre_q   <= pre_us_i;
            pulse_q <= pulse_us_i;
            post_q  <= post_us_i;
        end
    end

    p_line_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rst_o == ACT_LVL) |-> busy_o);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_captured_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(pre_q) && $stable(pulse_q) && $stable(post_q)));

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !phase_end) |=> $stable(state_q));

endmodule

// File: tb/phyrst_seq_test.sv
module phyrst_seq_test;
    localparam int N = 250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] pre_us_i = '0, pulse_us_i = '0, post_us_i = '0;
    logic        phy_rst_o, busy_o, done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    phyrst_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .pre_us_i(pre_us_i), .pulse_us_i(pulse_us_i), .post_us_i(post_us_i),
        .phy_rst_o(phy_rst_o), .busy_o(busy_o), .done_o(done_o)
    );

    // Expected line level in cycle k: low (active) only inside the pulse window
    function automatic logic exp_line(int k, int a, int b);
        return (k > a*N && k <= (a+b)*N) ? 1'b0 : 1'b1;
    endfunction

    task automatic check(string tag, bit ok, int cyc, int got, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, got, exp);
        end
    endtask

    // Run one sequence and compare every cycle against the computed waveform
    task automatic run_seq(int a, int b, int c, bit poke_start, bit poke_dly, string tag);
        int t, lk, bk, dk, lg, le, bg, be, dg, de;
        bit lok, bok, dok;
        t = (a + b + c) * N;
        lok = 1; bok = 1; dok = 1; lk = 0; bk = 0; dk = 0;
        lg = 0; le = 0; bg = 0; be = 0; dg = 0; de = 0;
        @(negedge clk);
        pre_us_i = a; pulse_us_i = b; post_us_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= t + 2; k++) begin
            if (k > 1) @(negedge clk);
            start_i = 1'b0;
            if (lok && phy_rst_o !== exp_line(k, a, b)) begin
                lok = 0; lk = k; lg = phy_rst_o; le = exp_line(k, a, b);
            end
            if (bok && busy_o !== (k <= t)) begin
                bok = 0; bk = k; bg = busy_o; be = (k <= t);
            end
            if (dok && done_o !== (k == t + 1)) begin
                dok = 0; dk = k; dg = done_o; de = (k == t + 1);
            end
            if (poke_start && k == 5 && t > 6) start_i = 1'b1;
            if (poke_dly && k == 3) begin
                pre_us_i = $urandom_range(0, 9); pulse_us_i = $urandom_range(0, 9);
                post_us_i = $urandom_range(0, 9);
            end
        end
        start_i = 1'b0;
        check({tag, " R2 R8 line"}, lok, lk, lg, le);
        check({tag, " R3 R9 busy"}, bok, bk, bg, be);
        check({tag, " R5 done"}, dok, dk, dg, de);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 line", phy_rst_o === 1'b1, 0, phy_rst_o, 1);
        check("R1 busy", busy_o === 1'b0, 0, busy_o, 0);
        check("R1 done", done_o === 1'b0, 0, done_o, 0);

        run_seq(2, 3, 1, 0, 0, "basic");
        run_seq(0, 2, 1, 0, 0, "R4 no settle");
        run_seq(1, 0, 1, 0, 0, "R4 no pulse");
        run_seq(1, 1, 0, 0, 0, "R4 no recovery");
        run_seq(0, 0, 0, 0, 0, "R4 all zero");
        run_seq(1, 1, 1, 0, 0, "single us");
        run_seq(2, 2, 2, 1, 0, "R7 strobe while busy");
        run_seq(1, 2, 1, 0, 1, "R6 inputs change");
        run_seq(0, 1, 0, 1, 1, "R6 R7 pulse only");
        for (int i = 0; i < 12; i++) begin
            run_seq($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4),
                    $urandom_range(0, 1), $urandom_range(0, 1), "random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule